// File: doc/BRIEF.md
# Half-Bridge Gate Command Interlock

This block sits between a digital PWM source and the two gate drivers of a half bridge. A single PWM level is converted into a high-side command and a complementary low-side command. A switch may turn on only after the other switch's off-state feedback has been seen and a programmable dead interval has then passed. All timing is counted in clock cycles. The block filters out PWM pulses that are too short to switch safely, and it locks itself out when a high level follows a low excursion that was too brief.

A low-side enable chooses between synchronous operation, where both switches are driven, and diode-conducting asynchronous operation, where the bottom switch stays off. An under-voltage flag forces both commands off. If the off-state feedback of a switch that has been commanded off does not arrive in time, a fault flag is raised and stays set until reset. Every input is passed through a two-stage synchronizer before any decision logic uses it.

Top module: `gate_interlock`

## Requirements
- R1: `hs_gate` and `ls_gate` are never high in the same cycle. After the filter, a high PWM level selects the high side and a low level selects the low side.
- R2: A gate command rises only after the opposite gate's synchronized off feedback has been seen high for `DEAD_CYC` further cycles. With feedback that follows the command instantly, one output rises exactly `DEAD_CYC`+3 cycles after the other output falls.
- R3: Counting the first clock edge that samples a `pwm_in` change as edge 0, `hs_gate` falls at edge 2+`MIN_W`+`HS_OFF_DLY` after a falling PWM edge, and `ls_gate` falls at edge 2+`MIN_W`+`LS_OFF_DLY` after a rising PWM edge.
- R4: While `ls_en_in` is low, `ls_gate` stays low and `hs_gate` still follows PWM. Dropping the enable while the low side is on clears `ls_gate` on the cycle after the synchronized enable falls.
- R5: While `uv_in` is high, both gate commands go low within 3 cycles and stay low whatever the PWM level.
- R6: After reset, and after `uv_in` is released, both commands stay low until the synchronized PWM has been low for `MIN_W` consecutive cycles.
- R7: During low-side operation, a high pulse shorter than `MIN_W` cycles is ignored and gives exactly one `pulse_rej` strobe. A high pulse of exactly `MIN_W` cycles is accepted and takes the low side off.
- R8: During high-side operation, a low excursion shorter than `MIN_W` cycles followed by a high level enters lockout: both commands go low and `pulse_rej` strobes once. Lockout ends only after PWM has been low for `MIN_W` consecutive cycles. Shorter lows, and high levels, keep both commands low.
- R9: If a gate that has been commanded off does not report off within `FB_TIMEOUT` cycles, `fb_fault` rises and stays high. From then until reset both commands remain low.
- R10: `pulse_rej` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_in | input | 1 | PWM request, 1 = high side, 0 = low side |
| ls_en_in | input | 1 | 1 = synchronous (low side driven), 0 = asynchronous |
| uv_in | input | 1 | Under-voltage flag, 1 = force both gates off |
| hs_off_fb | input | 1 | 1 = high-side gate observed off |
| ls_off_fb | input | 1 | 1 = low-side gate observed off |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |
| pulse_rej | output | 1 | One-cycle strobe: a short pulse was dropped or lockout was entered |
| fb_fault | output | 1 | Sticky feedback-timeout fault |

## Verification
The PWM input is driven with long alternating levels, which show the complementary hand-over, the turn-off latency on each edge and the feedback-to-dead-time gap. High pulses one cycle shorter than the minimum width and pulses of exactly the minimum width separate rejection from acceptance. A brief low inside a high period separates lockout from ordinary switching, and further short and long lows show which pattern ends the lockout. The same level patterns are then repeated with the enable low, with the under-voltage flag set, and with high-side feedback held stuck. These runs show that each override removes only the outputs it should.

// File: rtl/gi_pkg.sv
// Package: shared encodings for the gate interlock.
// Assumes: imported by every module of the interlock.
package gi_pkg;

    // Qualified request passed from the width filter to the sequencer
    typedef enum logic [1:0] {
        CMD_OFF = 2'd0,
        CMD_LO  = 2'd1,
        CMD_HI  = 2'd2
    } gate_cmd_t;

    // Width filter modes
    typedef enum logic [1:0] {
        F_ARM  = 2'd0,
        F_RUN  = 2'd1,
        F_LOCK = 2'd2
    } filt_st_t;

    // Gate sequencer states
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_HS_DEAD = 3'd1,
        S_HS_ON   = 3'd2,
        S_HS_OFF  = 3'd3,
        S_LS_DEAD = 3'd4,
        S_LS_ON   = 3'd5,
        S_LS_OFF  = 3'd6
    } seq_st_t;

endpackage

// File: rtl/gi_sync.sv
// Module: gi_sync
// Two-stage synchronizer for a vector of independent single-bit inputs.
// Assumes: each bit is a level signal, so bits may resolve on different cycles.
module gi_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] out_q;

    // Two flops in series per bit, both reset to the safe level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            out_q  <= RST_VAL;
        end else begin
            meta_q <= d;
            out_q  <= meta_q;
        end
    end

    assign q = out_q;
endmodule

// File: rtl/gi_width_filter.sv
// Module: gi_width_filter
// Qualifies the synchronized PWM level. A new level is accepted once it has
// held for MIN_W cycles. A short high pulse during low-side operation is dropped,
// and a short low excursion during high-side operation enters lockout. Lockout and
// the power-up arming state both end after MIN_W consecutive low cycles.
// Assumes: MIN_W >= 2 and a synchronized PWM input.
module gi_width_filter
    import gi_pkg::*;
#(
    parameter int MIN_W = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pwm_s,
    input  logic      uv_s,
    output gate_cmd_t cmd,
    output logic      pulse_rej
);
    localparam int          RW    = $clog2(MIN_W + 1);
    localparam logic [RW-1:0] RMAX = RW'(MIN_W);

    logic          p_d;
    logic [RW-1:0] run_q;
    logic [RW-1:0] run_now;
    logic          stable;
    filt_st_t      st_q;
    logic          lvl_q;
    logic          rej_q;

    // Length of the current run of equal levels, saturating at MIN_W
    always_comb begin
        if (pwm_s != p_d)     run_now = RW'(1);
        else if (run_q >= RMAX) run_now = RMAX;
        else                  run_now = run_q + 1'b1;
    end

    assign stable = (run_now >= RMAX);

    // Run-length history of the synchronized PWM
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_d   <= 1'b0;
            run_q <= '0;
        end else begin
            p_d   <= pwm_s;
            run_q <= run_now;
        end
    end

    // Arming, normal and lockout sequencing with the reject strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= F_ARM;
            lvl_q <= 1'b0;
            rej_q <= 1'b0;
        end else begin
            rej_q <= 1'b0;
            if (uv_s) begin
                st_q  <= F_ARM;
                lvl_q <= 1'b0;
            end else begin
                case (st_q)
                    F_ARM, F_LOCK: begin
                        if (!pwm_s && stable) begin
                            st_q  <= F_RUN;
                            lvl_q <= 1'b0;
                        end
                    end
                    F_RUN: begin
                        if (pwm_s != lvl_q) begin
                            if (stable) lvl_q <= pwm_s;
                        end else if (p_d != lvl_q) begin
                            rej_q <= 1'b1;
                            if (lvl_q) st_q <= F_LOCK;
                        end
                    end
                    default: st_q <= F_ARM;
                endcase
            end
        end
    end

    // Request presented to the sequencer
    always_comb begin
        if (st_q != F_RUN) cmd = CMD_OFF;
        else if (lvl_q)    cmd = CMD_HI;
        else               cmd = CMD_LO;
    end

    assign pulse_rej = rej_q;
endmodule

// File: rtl/gi_gate_seq.sv
// Module: gi_gate_seq
// Drives the two gate commands from the qualified request. A gate turns on
// only after the opposite gate's synchronized feedback reports off and DEAD_CYC
// further cycles have passed. Turn-off waits a per-side propagation delay.
// A watchdog per gate raises a sticky fault when a gate commanded off never
// reports off; the fault then holds both commands low.
// Assumes: DEAD_CYC, HS_OFF_DLY, LS_OFF_DLY >= 1; synchronized inputs.
module gi_gate_seq
    import gi_pkg::*;
#(
    parameter int DEAD_CYC   = 1,
    parameter int HS_OFF_DLY = 2,
    parameter int LS_OFF_DLY = 1,
    parameter int FB_TIMEOUT = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  gate_cmd_t cmd,
    input  logic      ls_en_s,
    input  logic      uv_s,
    input  logic      hs_off_s,
    input  logic      ls_off_s,
    output logic      hs_gate,
    output logic      ls_gate,
    output logic      fb_fault
);
    localparam int MAX_A = (DEAD_CYC > HS_OFF_DLY) ? DEAD_CYC : HS_OFF_DLY;
    localparam int MAXD  = (MAX_A > LS_OFF_DLY) ? MAX_A : LS_OFF_DLY;
    localparam int CW    = $clog2(MAXD + 1);
    localparam int WDW   = $clog2(FB_TIMEOUT + 1);
    localparam logic [CW-1:0] DEAD_END = CW'(DEAD_CYC - 1);
    localparam logic [CW-1:0] HS_END   = CW'(HS_OFF_DLY - 1);
    localparam logic [CW-1:0] LS_END   = CW'(LS_OFF_DLY - 1);
    localparam logic [WDW-1:0] WD_END  = WDW'(FB_TIMEOUT);

    seq_st_t       st_q;
    logic [CW-1:0] cnt_q;
    logic          fault_q;
    logic          want_hs;
    logic          want_ls;
    logic          hs_on;
    logic          ls_on;
    logic [1:0]    gate_on;
    logic [1:0]    off_fb;
    logic [1:0]    expired;

    assign want_hs = (cmd == CMD_HI);
    assign want_ls = (cmd == CMD_LO) && ls_en_s;
    assign hs_on   = (st_q == S_HS_ON) || (st_q == S_HS_OFF);
    assign ls_on   = (st_q == S_LS_ON) || (st_q == S_LS_OFF);
    assign gate_on = {hs_on, ls_on};
    assign off_fb  = {hs_off_s, ls_off_s};

    // One feedback watchdog per gate: index 1 high side, index 0 low side
    for (genvar g = 0; g < 2; g++) begin : g_wd
        logic [WDW-1:0] wd_q;

        // Count cycles a gate is commanded off yet still reports on
        always_ff @(posedge clk) begin
            if (!rst_n || gate_on[g] || off_fb[g]) wd_q <= '0;
            else if (wd_q != WD_END)               wd_q <= wd_q + 1'b1;
        end

        assign expired[g] = (wd_q == WD_END);
    end

    // Sticky fault, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= fault_q | (|expired);
    end

    // Break-before-make sequencing of the two gate commands
    always_ff @(posedge clk) begin
        if (!rst_n || uv_s || fault_q) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    cnt_q <= '0;
                    if (want_hs && ls_off_s)      st_q <= S_HS_DEAD;
                    else if (want_ls && hs_off_s) st_q <= S_LS_DEAD;
                end
                S_HS_DEAD: begin
                    if (!want_hs || !ls_off_s) begin
                        st_q  <= S_IDLE;
                        cnt_q <= '0;
                    end else if (cnt_q == DEAD_END) begin
                        st_q  <= S_HS_ON;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_HS_ON: begin
                    cnt_q <= '0;
                    if (!want_hs) st_q <= S_HS_OFF;
                end
                S_HS_OFF: begin
                    if (want_hs) begin
                        st_q  <= S_HS_ON;
                        cnt_q <= '0;
                    end else if (cnt_q == HS_END) begin
                        st_q  <= S_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_LS_DEAD: begin
                    if (!want_ls || !hs_off_s) begin
                        st_q  <= S_IDLE;
                        cnt_q <= '0;
                    end else if (cnt_q == DEAD_END) begin
                        st_q  <= S_LS_ON;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_LS_ON: begin
                    cnt_q <= '0;
                    if (!ls_en_s)     st_q <= S_IDLE;
                    else if (!want_ls) st_q <= S_LS_OFF;
                end
                S_LS_OFF: begin
                    if (!ls_en_s) begin
                        st_q  <= S_IDLE;
                        cnt_q <= '0;
                    end else if (want_ls) begin
                        st_q  <= S_LS_ON;
                        cnt_q <= '0;
                    end else if (cnt_q == LS_END) begin
                        st_q  <= S_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    st_q  <= S_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign hs_gate  = hs_on;
    assign ls_gate  = ls_on;
    assign fb_fault = fault_q;
endmodule

// File: rtl/gate_interlock.sv
// Module: gate_interlock (top)
// PWM to complementary gate commands with dead time, feedback interlock,
// minimum-width filtering, lockout, under-voltage override and feedback fault.
// Assumes: all inputs asynchronous to clk; times given in clock cycles.
module gate_interlock
    import gi_pkg::*;
#(
    parameter int MIN_W      = 3,
    parameter int DEAD_CYC   = 1,
    parameter int HS_OFF_DLY = 2,
    parameter int LS_OFF_DLY = 1,
    parameter int FB_TIMEOUT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    input  logic ls_en_in,
    input  logic uv_in,
    input  logic hs_off_fb,
    input  logic ls_off_fb,
    output logic hs_gate,
    output logic ls_gate,
    output logic pulse_rej,
    output logic fb_fault
);
    localparam int NSYNC = 5;
    // Feedback bits reset to "off", the rest to 0
    localparam logic [NSYNC-1:0] SYNC_RST = 5'b11000;

    logic [NSYNC-1:0] sync_q;
    logic      pwm_s;
    logic      ls_en_s;
    logic      uv_s;
    logic      hs_off_s;
    logic      ls_off_s;
    gate_cmd_t cmd;

    gi_sync #(
        .W       (NSYNC),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hs_off_fb, ls_off_fb, uv_in, ls_en_in, pwm_in}),
        .q     (sync_q)
    );

    assign {hs_off_s, ls_off_s, uv_s, ls_en_s, pwm_s} = sync_q;

    gi_width_filter #(
        .MIN_W (MIN_W)
    ) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_s     (pwm_s),
        .uv_s      (uv_s),
        .cmd       (cmd),
        .pulse_rej (pulse_rej)
    );

    gi_gate_seq #(
        .DEAD_CYC   (DEAD_CYC),
        .HS_OFF_DLY (HS_OFF_DLY),
        .LS_OFF_DLY (LS_OFF_DLY),
        .FB_TIMEOUT (FB_TIMEOUT)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .ls_en_s  (ls_en_s),
        .uv_s     (uv_s),
        .hs_off_s (hs_off_s),
        .ls_off_s (ls_off_s),
        .hs_gate  (hs_gate),
        .ls_gate  (ls_gate),
        .fb_fault (fb_fault)
    );
endmodule

// File: rtl/gate_interlock_chk.sv
// Module: gate_interlock_chk
// Temporal properties of the interlock, bound onto the top module.
// Assumes: reads the top-level ports and the synchronized inputs of the top.
module gate_interlock_chk (
    input logic clk,
    input logic rst_n,
    input logic hs_gate,
    input logic ls_gate,
    input logic pulse_rej,
    input logic fb_fault,
    input logic ls_en_s,
    input logic uv_s,
    input logic hs_off_s,
    input logic ls_off_s
);
    // R1: never both gates on
    p_never_both_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    // R2: high side rises only with the low side off and reported off
    p_hs_rise_fb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> ($past(ls_off_s) && !$past(ls_gate)));

    // R2: low side rises only with the high side off and reported off
    p_ls_rise_fb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> ($past(hs_off_s) && !$past(hs_gate)));

    // R4: disabled low side is off on the next cycle
    p_async_low_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ls_en_s |=> !ls_gate);

    // R5: under-voltage clears both gates
    p_uv_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |=> (!hs_gate && !ls_gate));

    // R6: release of under-voltage does not switch anything on at once
    p_hold_after_uv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uv_s) |=> (!hs_gate && !ls_gate));

    // R9: fault stays set
    p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fb_fault |=> fb_fault);

    // R9: fault holds both gates off
    p_fault_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fb_fault |=> (!hs_gate && !ls_gate));

    // R10: reject strobe lasts one cycle
    p_rej_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_rej |=> !pulse_rej);
endmodule

bind gate_interlock gate_interlock_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_gate   (hs_gate),
    .ls_gate   (ls_gate),
    .pulse_rej (pulse_rej),
    .fb_fault  (fb_fault),
    .ls_en_s   (ls_en_s),
    .uv_s      (uv_s),
    .hs_off_s  (hs_off_s),
    .ls_off_s  (ls_off_s)
);

// File: tb/gate_interlock_test.sv
module gate_interlock_test;
    localparam int MIN_W = 3;
    localparam int DEAD  = 1;
    localparam int HSD   = 2;
    localparam int LSD   = 1;
    localparam int TMO   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm = 1'b1;
    logic en = 1'b1;
    logic uv = 1'b0;
    logic stuck_hs = 1'b0;
    logic hs_gate, ls_gate, pulse_rej, fb_fault;
    logic hs_off_fb, ls_off_fb;

    // Plant model: feedback follows the command instantly unless stuck
    assign hs_off_fb = stuck_hs ? 1'b0 : !hs_gate;
    assign ls_off_fb = !ls_gate;

    gate_interlock #(
        .MIN_W (MIN_W), .DEAD_CYC (DEAD), .HS_OFF_DLY (HSD),
        .LS_OFF_DLY (LSD), .FB_TIMEOUT (TMO)
    ) uut (
        .clk (clk), .rst_n (rst_n), .pwm_in (pwm), .ls_en_in (en),
        .uv_in (uv), .hs_off_fb (hs_off_fb), .ls_off_fb (ls_off_fb),
        .hs_gate (hs_gate), .ls_gate (ls_gate), .pulse_rej (pulse_rej),
        .fb_fault (fb_fault)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic  hs;
        logic  ls;
        logic  flt;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   hs_fall_cyc = 0, hs_rise_cyc = 0, ls_fall_cyc = 0, ls_rise_cyc = 0;
    int   rej_cnt = 0;
    logic ls_dip = 1'b0;
    logic prev_hs = 1'b0, prev_ls = 1'b0;
    logic done = 1'b0;

    // Monitor: samples after each edge, tracks edges and scores the queue
    always @(posedge clk) begin
        #2;
        cyc++;
        if (prev_hs && !hs_gate) hs_fall_cyc = cyc;
        if (!prev_hs && hs_gate) hs_rise_cyc = cyc;
        if (prev_ls && !ls_gate) ls_fall_cyc = cyc;
        if (!prev_ls && ls_gate) ls_rise_cyc = cyc;
        if (pulse_rej) rej_cnt++;
        if (!ls_gate) ls_dip = 1'b1;
        prev_hs = hs_gate;
        prev_ls = ls_gate;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (hs_gate !== e.hs || ls_gate !== e.ls || fb_fault !== e.flt) begin
                errors++;
                $display("FAIL %s actual hs=%0d ls=%0d flt=%0d expected hs=%0d ls=%0d flt=%0d",
                         e.tag, hs_gate, ls_gate, fb_fault, e.hs, e.ls, e.flt);
            end
        end
    end

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side of the scoreboard
    task automatic expect_out(input logic h, input logic l, input logic f, input string tag);
        exp_t e;
        e.hs = h; e.ls = l; e.flt = f; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int t0;
        waitn(4);
        chk("reset hs R1", hs_gate, 0);
        chk("reset ls R1", ls_gate, 0);
        chk("reset fault R9", fb_fault, 0);
        chk("reset rej R10", pulse_rej, 0);
        rst_n = 1'b1;

        // R6: PWM high since reset keeps everything off
        waitn(20);
        expect_out(0, 0, 0, "R6 armed, pwm high");
        pwm = 1'b0;
        waitn(15);
        expect_out(0, 1, 0, "R6 low side after long low");

        // R3 / R2: rising edge hand-over
        t0 = cyc;
        pwm = 1'b1;
        waitn(15);
        chk("R3 low-side turn-off latency", ls_fall_cyc - t0, 3 + MIN_W + LSD);
        chk("R2 gap ls fall to hs rise", hs_rise_cyc - ls_fall_cyc, DEAD + 3);
        expect_out(1, 0, 0, "R1 high side on");

        // R3 / R2: falling edge hand-over
        t0 = cyc;
        pwm = 1'b0;
        waitn(15);
        chk("R3 high-side turn-off latency", hs_fall_cyc - t0, 3 + MIN_W + HSD);
        chk("R2 gap hs fall to ls rise", ls_rise_cyc - hs_fall_cyc, DEAD + 3);
        expect_out(0, 1, 0, "R1 low side on");

        // R7: short high pulse is ignored
        rej_cnt = 0; ls_dip = 1'b0;
        pwm = 1'b1; waitn(MIN_W - 1); pwm = 1'b0;
        waitn(15);
        chk("R7 short pulse strobes", rej_cnt, 1);
        chk("R7 low side undisturbed", ls_dip, 0);
        expect_out(0, 1, 0, "R7 after short pulse");

        // R7: pulse of exactly the minimum width is accepted
        rej_cnt = 0; ls_dip = 1'b0;
        pwm = 1'b1; waitn(MIN_W); pwm = 1'b0;
        waitn(15);
        chk("R7 min pulse no strobe", rej_cnt, 0);
        chk("R7 min pulse reaches gates", ls_dip, 1);
        expect_out(0, 1, 0, "R7 after min pulse");

        // R8: short low inside high period enters lockout
        pwm = 1'b1; waitn(15);
        expect_out(1, 0, 0, "R8 pre-lockout high");
        rej_cnt = 0;
        pwm = 1'b0; waitn(1); pwm = 1'b1;
        waitn(15);
        chk("R8 lockout strobe", rej_cnt, 1);
        expect_out(0, 0, 0, "R8 locked with pwm high");
        pwm = 1'b0; waitn(MIN_W - 1); pwm = 1'b1;
        waitn(15);
        expect_out(0, 0, 0, "R8 short low keeps lockout");
        chk("R10 no strobe inside lockout", rej_cnt, 1);
        pwm = 1'b0; waitn(15);
        expect_out(0, 1, 0, "R8 long low leaves lockout");
        pwm = 1'b1; waitn(15);
        expect_out(1, 0, 0, "R8 normal after lockout");

        // R4: asynchronous mode
        en = 1'b0; waitn(5);
        expect_out(1, 0, 0, "R4 high side kept");
        pwm = 1'b0; waitn(15);
        expect_out(0, 0, 0, "R4 low side held off");
        pwm = 1'b1; waitn(15);
        expect_out(1, 0, 0, "R4 high side follows");
        en = 1'b1; pwm = 1'b0; waitn(15);
        expect_out(0, 1, 0, "R4 sync restored");
        en = 1'b0; waitn(4);
        expect_out(0, 0, 0, "R4 enable drop clears low side");
        en = 1'b1; waitn(15);

        // R5 / R6: under-voltage
        uv = 1'b1; waitn(3);
        expect_out(0, 0, 0, "R5 uv clears gates");
        pwm = 1'b1; waitn(15);
        expect_out(0, 0, 0, "R5 uv with pwm high");
        uv = 1'b0; waitn(15);
        expect_out(0, 0, 0, "R6 held after uv release");
        pwm = 1'b0; waitn(15);
        expect_out(0, 1, 0, "R6 resumes after low");

        // R9: stuck high-side feedback
        pwm = 1'b1; waitn(15);
        stuck_hs = 1'b1;
        pwm = 1'b0; waitn(30);
        expect_out(0, 0, 1, "R9 fault raised");
        stuck_hs = 1'b0;
        pwm = 1'b1; waitn(15);
        pwm = 1'b0; waitn(15);
        expect_out(0, 0, 1, "R9 fault sticky");
        rst_n = 1'b0; waitn(3); rst_n = 1'b1;
        waitn(20);
        expect_out(0, 1, 0, "R9 reset clears fault");

        waitn(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule